// File: doc/BRIEF.md
# Dynamic Delay Code Adjuster

This block holds the delay code for one lane while skew is being trained. Training logic moves the code one step at a time. It raises a move strobe and picks the direction with a separate input. The code comes out as a signed digital bus. A registered flag goes high when a step asks for a value beyond the range of the bus. An active-low load input sets the code back to a default value. That default is fixed at build time by an 8-bit magnitude and a sign bit, which selects either the positive value or its two's complement.

The move strobe is synchronized and edge-detected inside the block, so each pulse counts once however long it stays high. A parameter selects one of three variants:

- **Read-path:** load acts asynchronously and holds the default for as long as it is low.
- **Write-path:** load does nothing by itself. The default is applied only when a complete low-high-low move pulse happens while load is low.
- **Write-leveling:** load acts asynchronously, as in the read-path variant, and the default is always zero.

Top module: `dca_top`

## Requirements
- R1: While reset is high and after it is released, the code equals the variant's default and the range flag is 0.
- R2: One rising edge of move changes the code by exactly one step. A move held high for many cycles produces a single step.
- R3: Direction 0 increments the code and direction 1 decrements it.
- R4: The code saturates at +(2^(CODE_W-1))-1 and -(2^(CODE_W-1)) and never wraps (+255 and -256 when CODE_W is 9).
- R5: The range flag is a register output. It goes to 1 when a step is requested past either limit, and stays at 1 until the next load.
- R6: The default code is -DEF_MAG when DEF_NEG is 1 and +DEF_MAG when DEF_NEG is 0, with DEF_MAG in 0..255.
- R7: In the read-path variant, load_n low sets the code to the default and clears the flag without waiting for a clock. Move pulses have no effect while load_n stays low.
- R8: In the write-path variant, load_n low without a move pulse leaves the code unchanged. When a move pulse ends while load_n is low, the code is set to the default and the flag is cleared, and no step is taken.
- R9: The write-leveling variant loads and resets to a code of zero whatever DEF_MAG and DEF_NEG are.
- R10: A step appears on the code at the third rising clock edge after move rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| load_n | input | 1 | Load default, active low |
| move | input | 1 | Step strobe, acts on its rising edge |
| dir | input | 1 | Step direction: 0 up, 1 down |
| code_o | output | CODE_W | Current signed delay code |
| range_flag_o | output | 1 | Registered out-of-range flag |

## Verification
The step, no-wrap and sticky-flag properties assume three things about the inputs:
- load_n is held low across at least one clock edge whenever it is asserted.
- load_n changes only away from a rising clock edge.
- dir is stable while a move pulse is in flight.

The bench meets these assumptions as follows:
- It drives every input on the falling clock edge.
- It keeps each move pulse high for four cycles and low for four cycles.
- It changes dir only between pulses.
- It holds load_n low for at least a full pulse.

The random mix draws the direction of each pulse and, now and then, a load sequence. Directed runs drive the code into both limits.

// File: rtl/dca_pkg.sv
package dca_pkg;

    typedef enum logic [1:0] {
        DCA_READ  = 2'd0,
        DCA_WRITE = 2'd1,
        DCA_WRLVL = 2'd2
    } dca_variant_e;

    // Default code as an integer: sign-magnitude build, zero for write leveling
    function automatic int dca_default(dca_variant_e v, logic neg, logic [7:0] mag);
        int r;
        if (v == DCA_WRLVL) r = 0;
        else if (neg)       r = -int'(mag);
        else                r = int'(mag);
        return r;
    endfunction

endpackage

// File: rtl/dca_move_sync.sv
module dca_move_sync (
    input  logic clk,
    input  logic rst,
    input  logic move,
    output logic rise_o,
    output logic fall_o
);
    logic s1_q, s2_q, prev_q;
    logic s1_d, s2_d, prev_d;

    always_comb begin
        s1_d   = move;
        s2_d   = s1_q;
        prev_d = s2_q;
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            s1_q   <= 1'b0;
            s2_q   <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            s1_q   <= s1_d;
            s2_q   <= s2_d;
            prev_q <= prev_d;
        end
    end

    assign rise_o = s2_q & ~prev_q;
    assign fall_o = ~s2_q & prev_q;
endmodule

// File: rtl/dca_step.sv
module dca_step #(
    parameter int CODE_W = 9
) (
    input  logic signed [CODE_W-1:0] code_i,
    input  logic                     flag_i,
    input  logic                     dir_i,
    output logic signed [CODE_W-1:0] code_o,
    output logic                     flag_o
);
    localparam logic signed [CODE_W-1:0] MAX_C = {1'b0, {(CODE_W-1){1'b1}}};
    localparam logic signed [CODE_W-1:0] MIN_C = {1'b1, {(CODE_W-1){1'b0}}};
    localparam logic        [CODE_W-1:0] ONE   = {{(CODE_W-1){1'b0}}, 1'b1};

    always_comb begin
        code_o = code_i;
        flag_o = flag_i;
        if (!dir_i) begin
            if (code_i == MAX_C) flag_o = 1'b1;
            else                 code_o = code_i + ONE;
        end else begin
            if (code_i == MIN_C) flag_o = 1'b1;
            else                 code_o = code_i - ONE;
        end
    end
endmodule

// File: rtl/dca_top.sv
module dca_top #(
    parameter int                    CODE_W  = 9,
    parameter logic [7:0]            DEF_MAG = 8'd0,
    parameter logic                  DEF_NEG = 1'b0,
    parameter dca_pkg::dca_variant_e VARIANT = dca_pkg::DCA_READ
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     load_n,
    input  logic                     move,
    input  logic                     dir,
    output logic signed [CODE_W-1:0] code_o,
    output logic                     range_flag_o
);
    import dca_pkg::*;

    localparam int                       DEF_I    = dca_default(VARIANT, DEF_NEG, DEF_MAG);
    localparam logic signed [CODE_W-1:0] DEF_CODE = DEF_I[CODE_W-1:0];

    typedef struct packed {
        logic signed [CODE_W-1:0] code;
        logic                     flag;
    } st_t;

    localparam st_t LOAD_ST = '{code: DEF_CODE, flag: 1'b0};

    st_t  st_d, st_q;
    logic rise, fall;
    logic signed [CODE_W-1:0] step_code;
    logic                     step_flag;

    dca_move_sync u_sync (
        .clk    (clk),
        .rst    (rst),
        .move   (move),
        .rise_o (rise),
        .fall_o (fall)
    );

    dca_step #(.CODE_W(CODE_W)) u_step (
        .code_i (st_q.code),
        .flag_i (st_q.flag),
        .dir_i  (dir),
        .code_o (step_code),
        .flag_o (step_flag)
    );

    always_comb begin
        st_d = st_q;
        if (VARIANT == DCA_WRITE) begin
            if (!load_n && fall)     st_d = LOAD_ST;
            else if (load_n && rise) st_d = '{code: step_code, flag: step_flag};
        end else if (rise) begin
            st_d = '{code: step_code, flag: step_flag};
        end
    end

    generate
        if (VARIANT == DCA_WRITE) begin : g_sync_load
            always_ff @(posedge clk or posedge rst) begin
                if (rst) st_q <= LOAD_ST;
                else     st_q <= st_d;
            end
        end else begin : g_async_load
            always_ff @(posedge clk or posedge rst or negedge load_n) begin
                if (rst)          st_q <= LOAD_ST;
                else if (!load_n) st_q <= LOAD_ST;
                else              st_q <= st_d;
            end
        end
    endgenerate

    assign code_o       = st_q.code;
    assign range_flag_o = st_q.flag;
endmodule

// File: rtl/dca_checker.sv
module dca_checker #(
    parameter int                    CODE_W  = 9,
    parameter logic [7:0]            DEF_MAG = 8'd0,
    parameter logic                  DEF_NEG = 1'b0,
    parameter dca_pkg::dca_variant_e VARIANT = dca_pkg::DCA_READ
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     load_n,
    input logic signed [CODE_W-1:0] code_o,
    input logic                     range_flag_o
);
    localparam int TOP_I = (1 << (CODE_W-1)) - 1;
    localparam int BOT_I = -(1 << (CODE_W-1));
    localparam int EXP_I = (VARIANT == dca_pkg::DCA_WRLVL) ? 0 :
                           (DEF_NEG ? -int'(DEF_MAG) : int'(DEF_MAG));

    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (rst)
        (load_n && $past(load_n)) |->
        ((int'(code_o) - int'($past(code_o))) inside {-1, 0, 1})); // R2

    AST_NO_WRAP_HIGH: assert property (@(posedge clk) disable iff (rst)
        (load_n && $past(load_n) && int'($past(code_o)) == TOP_I) |->
        (int'(code_o) != BOT_I)); // R4

    AST_NO_WRAP_LOW: assert property (@(posedge clk) disable iff (rst)
        (load_n && $past(load_n) && int'($past(code_o)) == BOT_I) |->
        (int'(code_o) != TOP_I)); // R4

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        ($past(range_flag_o) && load_n && $past(load_n)) |-> range_flag_o); // R5

    AST_FLAG_AT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        $rose(range_flag_o) |-> (int'(code_o) == TOP_I || int'(code_o) == BOT_I)); // R5

    generate
        if (VARIANT != dca_pkg::DCA_WRITE) begin : g_async
            AST_LOAD_ASYNC: assert property (@(posedge clk) disable iff (rst)
                !load_n |-> (int'(code_o) == EXP_I && !range_flag_o)); // R7
        end
        if (VARIANT == dca_pkg::DCA_WRLVL) begin : g_wl
            AST_WL_ZERO: assert property (@(posedge clk) disable iff (rst)
                !load_n |-> (code_o == '0)); // R9
        end
    endgenerate
endmodule

bind dca_top dca_checker #(
    .CODE_W  (CODE_W),
    .DEF_MAG (DEF_MAG),
    .DEF_NEG (DEF_NEG),
    .VARIANT (VARIANT)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .load_n       (load_n),
    .code_o       (code_o),
    .range_flag_o (range_flag_o)
);

// File: tb/dca_top_test.sv
module dca_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int W    = 9;
    localparam int MAXV = 255;
    localparam int MINV = -256;

    logic clk = 1'b0;
    logic rst, load_n, move, dir;
    logic signed [W-1:0] code_rd, code_wr, code_wl;
    logic flag_rd, flag_wr, flag_wl;

    int errors = 0;
    int checks = 0;
    int m_code [3];
    bit m_flag [3];
    int defv   [3];

    always #(CLK_PERIOD/2) clk = ~clk;

    dca_top #(.CODE_W(W), .DEF_MAG(8'd5), .DEF_NEG(1'b1), .VARIANT(dca_pkg::DCA_READ)) uut (
        .clk(clk), .rst(rst), .load_n(load_n), .move(move), .dir(dir),
        .code_o(code_rd), .range_flag_o(flag_rd));
    dca_top #(.CODE_W(W), .DEF_MAG(8'd10), .DEF_NEG(1'b0), .VARIANT(dca_pkg::DCA_WRITE)) uut_wr (
        .clk(clk), .rst(rst), .load_n(load_n), .move(move), .dir(dir),
        .code_o(code_wr), .range_flag_o(flag_wr));
    dca_top #(.CODE_W(W), .DEF_MAG(8'd77), .DEF_NEG(1'b1), .VARIANT(dca_pkg::DCA_WRLVL)) uut_wl (
        .clk(clk), .rst(rst), .load_n(load_n), .move(move), .dir(dir),
        .code_o(code_wl), .range_flag_o(flag_wl));

    function automatic int act_code(int i);
        if (i == 0) return int'(code_rd);
        if (i == 1) return int'(code_wr);
        return int'(code_wl);
    endfunction

    function automatic int act_flag(int i);
        if (i == 0) return int'(flag_rd);
        if (i == 1) return int'(flag_wr);
        return int'(flag_wl);
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_all(string req);
        for (int i = 0; i < 3; i++) begin
            chk($sformatf("%s code inst%0d", req, i), act_code(i), m_code[i]);
            chk($sformatf("%s flag inst%0d", req, i), act_flag(i), int'(m_flag[i]));
        end
    endtask

    // Model of one step: R3 direction, R4 saturation, R5 flag
    task automatic model_step(int i, bit d);
        if (!d) begin
            if (m_code[i] == MAXV) m_flag[i] = 1'b1; else m_code[i]++;
        end else begin
            if (m_code[i] == MINV) m_flag[i] = 1'b1; else m_code[i]--;
        end
    endtask

    task automatic pulse(bit d, string req);
        dir  = d;
        move = 1'b1;
        repeat (4) @(negedge clk);
        move = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            if (load_n) model_step(i, d);
            else if (i == 1) begin m_code[1] = defv[1]; m_flag[1] = 1'b0; end
        end
        check_all(req);
    endtask

    task automatic load_low();
        load_n = 1'b0;
        #1;
        m_code[0] = defv[0]; m_flag[0] = 1'b0;
        m_code[2] = defv[2]; m_flag[2] = 1'b0;
        chk("R7 async load code", int'(code_rd), defv[0]);
        chk("R7 async load flag", int'(flag_rd), 0);
        chk("R9 wl async load zero", int'(code_wl), 0);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        defv[0] = -5; defv[1] = 10; defv[2] = 0;
        rst = 1'b1; load_n = 1'b1; move = 1'b0; dir = 1'b0;
        for (int i = 0; i < 3; i++) begin m_code[i] = defv[i]; m_flag[i] = 1'b0; end
        repeat (3) @(negedge clk);
        check_all("R1 R6 R9 in reset");
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check_all("R1 after reset");

        // R10 latency and R2 single step on held move
        dir = 1'b0;
        move = 1'b1;
        @(negedge clk);
        chk("R10 no change after edge 1", int'(code_rd), -5);
        @(negedge clk);
        chk("R10 no change after edge 2", int'(code_rd), -5);
        @(negedge clk);
        chk("R10 step at edge 3", int'(code_rd), -4);
        repeat (20) @(negedge clk);
        for (int i = 0; i < 3; i++) model_step(i, 1'b0);
        check_all("R2 held move one step");
        move = 1'b0;
        repeat (4) @(negedge clk);
        check_all("R2 after release");

        // R3 direction
        pulse(1'b0, "R3 up");
        pulse(1'b0, "R3 up");
        pulse(1'b1, "R3 down");

        // R8 write load needs pulse; R7 moves ignored while low
        load_low();
        repeat (5) @(negedge clk);
        check_all("R8 load without pulse");
        pulse(1'b0, "R8 R7 load pulse");
        pulse(1'b1, "R8 R7 second pulse");
        @(negedge clk);
        load_n = 1'b1;
        @(negedge clk);
        check_all("R7 R8 after load release");

        // R4 R5 low saturation
        for (int k = 0; k < 270; k++) pulse(1'b1, "R4 drive down");
        chk("R4 rd at min", int'(code_rd), MINV);
        chk("R5 rd flag set", int'(flag_rd), 1);
        chk("R5 wr flag set", int'(flag_wr), 1);
        pulse(1'b0, "R5 flag sticky after up step");
        chk("R5 rd flag still set", int'(flag_rd), 1);
        load_low();
        pulse(1'b0, "R5 R8 clear by load");
        load_n = 1'b1;
        @(negedge clk);
        check_all("R5 flags cleared");

        // R4 R5 high saturation
        for (int k = 0; k < 270; k++) pulse(1'b0, "R4 drive up");
        chk("R4 wl at max", int'(code_wl), MAXV);
        chk("R5 wl flag set", int'(flag_wl), 1);

        // random mix
        for (int k = 0; k < 150; k++) begin
            if ($urandom % 10 == 0) begin
                load_low();
                pulse(1'(($urandom) & 1), "R7 R8 random load");
                load_n = 1'b1;
                @(negedge clk);
                check_all("R7 R8 random release");
            end else begin
                pulse(1'(($urandom) & 1), "R2 R3 random step");
            end
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule